// File: doc/BRIEF.md
# Twelve-Hour Alarm Clock Core

This core keeps time of day as three pairs of BCD digits (hours, minutes, seconds) in twelve-hour form, with a separate flag that marks afternoon. It runs on a single system clock. A one-second enable advances the time, and a quarter-second enable drives the display blink phase and the beeping alarm tone. Seven-segment decoding, button debouncing and the generation of both enables belong to the surrounding logic.

A mode button, pressed as a one-cycle pulse, walks the core through normal running and three adjust states. In an adjust state, time keeping stops, a set pulse advances only the chosen field, and that field's digits flash so the user can see which one is selected. An alarm time (hours, minutes, afternoon flag and a tone style) is loaded by a strobe. From then on the alarm is armed. When the running clock reaches that time at zero seconds, the buzzer sounds for five seconds, either steadily or as a beep.

Top module: `alarm_clock_core`

## Requirements
- R1: While reset is asserted, and after it is released, the time reads 12:00:00 with pm low, the mode is normal run, all three blank outputs are low, the buzzer is low and no alarm is armed.
- R2: In normal run, each tick_1s advances seconds through 00..59. Going from 59 to 00 advances minutes, and minutes going from 59 to 00 advances hours. Each digit is plain BCD (hr_tens is 0 or 1).
- R3: Hours follow the order 12, 01, 02, ..., 11, 12. pm flips when the hours go from 11 to 12, which in normal run happens at 11:59:59 to 12:00:00.
- R4: Each mode_btn pulse steps the mode in a fixed cycle: run, adjust hours, adjust minutes, adjust seconds, then back to run.
- R5: In any adjust mode, tick_1s leaves hours, minutes, seconds and pm unchanged.
- R6: set_btn advances only the field that is being adjusted, by one. Seconds and minutes wrap from 59 to 00 with no carry into any other field. In normal run, set_btn has no effect.
- R7: When set_btn advances the hours from 11 to 12 in hour-adjust mode, pm flips. No other field changes.
- R8: After an adjustment that wrapped a field to 00, the first tick in normal run advances only the seconds, by one. No carry left over from the edit reaches a higher field.
- R9: A quarter-phase count is cleared by tick_1s and advanced modulo 4 by tick_qtr (tick_1s wins if both are high). The blank output of the field under adjustment is high while this count is 2 or 3. Every other blank output stays low.
- R10: An alarm_wr pulse stores the alarm hours, minutes, pm and beep style, and arms the alarm. The alarm fires when a running tick brings the time to the stored hours and minutes, with seconds at 00 and a matching pm.
- R11: After the alarm fires, the alarm stays active until the fifth following tick_1s, so it is active for five seconds. A new firing reloads the full window.
- R12: With the beep style stored as 0, the buzzer is high for the whole active window. With the beep style stored as 1, the buzzer is high only while the quarter-phase count is even, which gives a 2 Hz tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear, released synchronously inside |
| tick_1s | input | 1 | One-cycle enable once per second |
| tick_qtr | input | 1 | One-cycle enable four times per second |
| mode_btn | input | 1 | Debounced one-cycle mode step pulse |
| set_btn | input | 1 | Debounced one-cycle field advance pulse |
| alarm_wr | input | 1 | Strobe that loads and arms the alarm time |
| alarm_hr_tens | input | 4 | Alarm hours tens digit (BCD) |
| alarm_hr_ones | input | 4 | Alarm hours ones digit (BCD) |
| alarm_min_tens | input | 4 | Alarm minutes tens digit (BCD) |
| alarm_min_ones | input | 4 | Alarm minutes ones digit (BCD) |
| alarm_pm | input | 1 | Alarm afternoon flag |
| alarm_beep | input | 1 | Alarm tone style: 1 beeps at 2 Hz, 0 is steady |
| hr_tens | output | 4 | Hours tens digit |
| hr_ones | output | 4 | Hours ones digit |
| min_tens | output | 4 | Minutes tens digit |
| min_ones | output | 4 | Minutes ones digit |
| sec_tens | output | 4 | Seconds tens digit |
| sec_ones | output | 4 | Seconds ones digit |
| pm | output | 1 | Afternoon indicator |
| blank_hr | output | 1 | Hours digits dark in the current blink phase |
| blank_min | output | 1 | Minutes digits dark in the current blink phase |
| blank_sec | output | 1 | Seconds digits dark in the current blink phase |
| buzzer | output | 1 | Alarm sound drive |

## Verification
The states that are hardest to reach from the ports are the wrap points: 11:59:59 changing to the next half-day, and an alarm time far from the reset time. Plain running would need tens of thousands of ticks to get there. The bench uses the adjust modes and the set pulse to move each field to any value in a few dozen pulses, then returns to run mode and ticks across the boundary. The same approach sets up a field that wraps to 00 during an edit before the first run tick. A random mix of ticks, quarter ticks, mode steps and set pulses is compared against a reference model after every operation. Directed alarm sequences then measure the five-second window, check that a pm mismatch does not fire, and check the beep gating against the quarter phase.

// File: rtl/clk_core_pkg.sv
package clk_core_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HOUR = 2'd1,
    MODE_MIN  = 2'd2,
    MODE_SEC  = 2'd3
  } edit_mode_e;
endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr #(
  parameter int unsigned TENS_MAX = 5,
  parameter int unsigned ONES_MAX = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  output logic [3:0] tens,
  output logic [3:0] ones,
  output logic       at_max
);
  localparam logic [3:0] T_MAX = 4'(TENS_MAX);
  localparam logic [3:0] O_MAX = 4'(ONES_MAX);

  logic [3:0] tens_q, ones_q, tens_n, ones_n;

  assign at_max = (tens_q == T_MAX) && (ones_q == O_MAX);

  always_comb begin
    tens_n = tens_q;
    ones_n = ones_q;
    if (inc) begin
      if (ones_q == O_MAX) begin
        ones_n = 4'd0;
        tens_n = (tens_q == T_MAX) ? 4'd0 : tens_q + 4'd1;
      end else begin
        ones_n = ones_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q <= 4'd0;
      ones_q <= 4'd0;
    end else if (inc) begin
      tens_q <= tens_n;
      ones_q <= ones_n;
    end
  end

  assign tens = tens_q;
  assign ones = ones_q;

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q <= O_MAX) && (tens_q <= T_MAX));
endmodule

// File: rtl/hour12_ctr.sv
module hour12_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  output logic [3:0] tens,
  output logic [3:0] ones,
  output logic       pm
);
  logic [3:0] tens_q, ones_q, tens_n, ones_n;
  logic       pm_q, pm_n;
  logic       is_twelve, is_eleven;

  assign is_twelve = (tens_q == 4'd1) && (ones_q == 4'd2);
  assign is_eleven = (tens_q == 4'd1) && (ones_q == 4'd1);

  always_comb begin
    tens_n = tens_q;
    ones_n = ones_q;
    pm_n   = pm_q;
    if (inc) begin
      if (is_twelve) begin
        tens_n = 4'd0;
        ones_n = 4'd1;
      end else if (ones_q == 4'd9) begin
        tens_n = 4'd1;
        ones_n = 4'd0;
      end else begin
        ones_n = ones_q + 4'd1;
      end
      if (is_eleven) pm_n = ~pm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q <= 4'd1;
      ones_q <= 4'd2;
      pm_q   <= 1'b0;
    end else if (inc) begin
      tens_q <= tens_n;
      ones_q <= ones_n;
      pm_q   <= pm_n;
    end
  end

  assign tens = tens_q;
  assign ones = ones_q;
  assign pm   = pm_q;

  // R3
  hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_q == 4'd0) ? (ones_q >= 4'd1 && ones_q <= 4'd9)
                     : (tens_q == 4'd1 && ones_q <= 4'd2));

  // R3
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_q != $past(pm_q)) |-> (tens_q == 4'd1 && ones_q == 4'd2));
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit #(
  parameter int unsigned RING_SECS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [3:0] wr_hr_tens,
  input  logic [3:0] wr_hr_ones,
  input  logic [3:0] wr_min_tens,
  input  logic [3:0] wr_min_ones,
  input  logic       wr_pm,
  input  logic       wr_beep,
  input  logic [3:0] cur_hr_tens,
  input  logic [3:0] cur_hr_ones,
  input  logic [3:0] cur_min_tens,
  input  logic [3:0] cur_min_ones,
  input  logic [3:0] cur_sec_tens,
  input  logic [3:0] cur_sec_ones,
  input  logic       cur_pm,
  input  logic       run_tick,
  input  logic       tick_1s,
  input  logic       tone_phase,
  output logic       buzzer
);
  localparam int unsigned CNT_W = $clog2(RING_SECS + 1);
  localparam logic [CNT_W-1:0] RING_LOAD = CNT_W'(RING_SECS);

  logic [3:0]       a_hr_t, a_hr_o, a_min_t, a_min_o;
  logic             a_pm, a_beep, armed, ran_q;
  logic [CNT_W-1:0] left_q, left_n;
  logic             fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hr_t  <= 4'd0;
      a_hr_o  <= 4'd0;
      a_min_t <= 4'd0;
      a_min_o <= 4'd0;
      a_pm    <= 1'b0;
      a_beep  <= 1'b0;
      armed   <= 1'b0;
    end else if (wr) begin
      a_hr_t  <= wr_hr_tens;
      a_hr_o  <= wr_hr_ones;
      a_min_t <= wr_min_tens;
      a_min_o <= wr_min_ones;
      a_pm    <= wr_pm;
      a_beep  <= wr_beep;
      armed   <= 1'b1;
    end
  end

  // Match is taken on the time settled one cycle after a running tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ran_q <= 1'b0;
    else        ran_q <= run_tick;
  end

  assign fire = ran_q && armed
             && (cur_hr_tens == a_hr_t) && (cur_hr_ones == a_hr_o)
             && (cur_min_tens == a_min_t) && (cur_min_ones == a_min_o)
             && (cur_pm == a_pm)
             && (cur_sec_tens == 4'd0) && (cur_sec_ones == 4'd0);

  always_comb begin
    left_n = left_q;
    if (fire)
      left_n = RING_LOAD;
    else if (tick_1s && (left_q != '0))
      left_n = left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_n;
  end

  assign buzzer = (left_q != '0) && (!a_beep || tone_phase);

  // R11
  ring_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= RING_LOAD);

  // R10
  buzz_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buzzer |-> armed);

  // R11
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_q != '0) && !tick_1s) |=> (left_q != '0));
endmodule

// File: rtl/alarm_clock_core.sv
module alarm_clock_core
  import clk_core_pkg::*;
#(
  parameter int unsigned RING_SECS = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1s,
  input  logic       tick_qtr,
  input  logic       mode_btn,
  input  logic       set_btn,
  input  logic       alarm_wr,
  input  logic [3:0] alarm_hr_tens,
  input  logic [3:0] alarm_hr_ones,
  input  logic [3:0] alarm_min_tens,
  input  logic [3:0] alarm_min_ones,
  input  logic       alarm_pm,
  input  logic       alarm_beep,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic       pm,
  output logic       blank_hr,
  output logic       blank_min,
  output logic       blank_sec,
  output logic       buzzer
);
  localparam int unsigned QTR_W = 2;

  // Reset: asserted at once, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  // Mode sequencer.
  edit_mode_e mode_q, mode_n;

  always_comb begin
    mode_n = mode_q;
    if (mode_btn) begin
      unique case (mode_q)
        MODE_RUN:  mode_n = MODE_HOUR;
        MODE_HOUR: mode_n = MODE_MIN;
        MODE_MIN:  mode_n = MODE_SEC;
        default:   mode_n = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= MODE_RUN;
    else            mode_q <= mode_n;
  end

  // Quarter-second phase: cleared by the second tick.
  logic [QTR_W-1:0] qph_q, qph_n;

  always_comb begin
    qph_n = qph_q;
    if (tick_1s)       qph_n = '0;
    else if (tick_qtr) qph_n = qph_q + QTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) qph_q <= '0;
    else            qph_q <= qph_n;
  end

  // Increment enables: carries only pass in run mode.
  logic run_tick, sec_max, min_max;
  logic sec_inc, min_inc, hr_inc;

  assign run_tick = tick_1s && (mode_q == MODE_RUN);
  assign sec_inc  = run_tick || (set_btn && mode_q == MODE_SEC);
  assign min_inc  = (run_tick && sec_max) || (set_btn && mode_q == MODE_MIN);
  assign hr_inc   = (run_tick && sec_max && min_max)
                 || (set_btn && mode_q == MODE_HOUR);

  bcd_field_ctr #(.TENS_MAX(5), .ONES_MAX(9)) u_sec (
    .clk(clk), .rst_n(rst_int_n), .inc(sec_inc),
    .tens(sec_tens), .ones(sec_ones), .at_max(sec_max)
  );

  bcd_field_ctr #(.TENS_MAX(5), .ONES_MAX(9)) u_min (
    .clk(clk), .rst_n(rst_int_n), .inc(min_inc),
    .tens(min_tens), .ones(min_ones), .at_max(min_max)
  );

  hour12_ctr u_hr (
    .clk(clk), .rst_n(rst_int_n), .inc(hr_inc),
    .tens(hr_tens), .ones(hr_ones), .pm(pm)
  );

  // Blink: dark during the second half of each second.
  logic dark_half;
  assign dark_half = qph_q[QTR_W-1];
  assign blank_hr  = dark_half && (mode_q == MODE_HOUR);
  assign blank_min = dark_half && (mode_q == MODE_MIN);
  assign blank_sec = dark_half && (mode_q == MODE_SEC);

  alarm_unit #(.RING_SECS(RING_SECS)) u_alarm (
    .clk(clk), .rst_n(rst_int_n),
    .wr(alarm_wr),
    .wr_hr_tens(alarm_hr_tens), .wr_hr_ones(alarm_hr_ones),
    .wr_min_tens(alarm_min_tens), .wr_min_ones(alarm_min_ones),
    .wr_pm(alarm_pm), .wr_beep(alarm_beep),
    .cur_hr_tens(hr_tens), .cur_hr_ones(hr_ones),
    .cur_min_tens(min_tens), .cur_min_ones(min_ones),
    .cur_sec_tens(sec_tens), .cur_sec_ones(sec_ones),
    .cur_pm(pm),
    .run_tick(run_tick), .tick_1s(tick_1s),
    .tone_phase(~qph_q[0]),
    .buzzer(buzzer)
  );

  logic [1:0] mode_bits;
  assign mode_bits = mode_q;

  // R4
  mode_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_btn |=> (mode_bits == $past(mode_bits) + 2'd1));

  // R5
  edit_min_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode_q != MODE_RUN) && !(set_btn && mode_q == MODE_MIN))
      |=> ($stable(min_tens) && $stable(min_ones)));

  // R5
  edit_hr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode_q != MODE_RUN) && !(set_btn && mode_q == MODE_HOUR))
      |=> ($stable(hr_tens) && $stable(hr_ones) && $stable(pm)));

  // R9
  blank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({blank_hr, blank_min, blank_sec}));
endmodule

// File: tb/test_alarm_clock_core.sv
module test_alarm_clock_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1s = 0, tick_qtr = 0, mode_btn = 0, set_btn = 0, alarm_wr = 0;
  logic [3:0] a_ht = 0, a_ho = 0, a_mt = 0, a_mo = 0;
  logic a_pm_in = 0, a_beep_in = 0;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;
  logic pm, blank_hr, blank_min, blank_sec, buzzer;

  int checks = 0;
  int errors = 0;

  // reference model state
  int mh, mm, ms, mpm, mmode, mq;
  int marmed, mah, mam, mapm, mabeep, mleft;

  always #10 clk = ~clk;

  alarm_clock_core i_alarm_clock_core (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .tick_qtr(tick_qtr),
    .mode_btn(mode_btn), .set_btn(set_btn), .alarm_wr(alarm_wr),
    .alarm_hr_tens(a_ht), .alarm_hr_ones(a_ho),
    .alarm_min_tens(a_mt), .alarm_min_ones(a_mo),
    .alarm_pm(a_pm_in), .alarm_beep(a_beep_in),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
    .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones),
    .pm(pm), .blank_hr(blank_hr), .blank_min(blank_min),
    .blank_sec(blank_sec), .buzzer(buzzer)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void hour_adv();
    if (mh == 11) begin mh = 12; mpm ^= 1; end
    else if (mh == 12) mh = 1;
    else mh++;
  endfunction

  function automatic void model_reset();
    mh = 12; mm = 0; ms = 0; mpm = 0; mmode = 0; mq = 0;
    marmed = 0; mah = 0; mam = 0; mapm = 0; mabeep = 0; mleft = 0;
  endfunction

  function automatic void model_tick();
    if (mmode == 0) begin
      ms++;
      if (ms == 60) begin
        ms = 0; mm++;
        if (mm == 60) begin mm = 0; hour_adv(); end
      end
    end
    if (mleft > 0) mleft--;
    if (mmode == 0 && marmed == 1 && mh == mah && mm == mam && ms == 0 && mpm == mapm)
      mleft = 5;
    mq = 0;
  endfunction

  function automatic void model_set();
    case (mmode)
      1: hour_adv();
      2: mm = (mm + 1) % 60;
      3: ms = (ms + 1) % 60;
      default: ;
    endcase
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "hr_tens", int'(hr_tens), mh / 10);
    chk(tag, "hr_ones", int'(hr_ones), mh % 10);
    chk(tag, "min_tens", int'(min_tens), mm / 10);
    chk(tag, "min_ones", int'(min_ones), mm % 10);
    chk(tag, "sec_tens", int'(sec_tens), ms / 10);
    chk(tag, "sec_ones", int'(sec_ones), ms % 10);
    chk(tag, "pm", int'(pm), mpm);
    chk(tag, "blank_hr", int'(blank_hr), int'(mmode == 1 && mq >= 2));
    chk(tag, "blank_min", int'(blank_min), int'(mmode == 2 && mq >= 2));
    chk(tag, "blank_sec", int'(blank_sec), int'(mmode == 3 && mq >= 2));
    chk(tag, "buzzer", int'(buzzer), int'(mleft > 0 && (mabeep == 0 || (mq % 2) == 0)));
  endtask

  // op: 0 tick, 1 quarter tick, 2 mode, 3 set
  task automatic apply(input int op, input bit do_cmp, input string tag);
    @(negedge clk);
    case (op)
      0: begin tick_1s = 1; tick_qtr = 1; end
      1: tick_qtr = 1;
      2: mode_btn = 1;
      default: set_btn = 1;
    endcase
    @(negedge clk);
    tick_1s = 0; tick_qtr = 0; mode_btn = 0; set_btn = 0;
    @(negedge clk);
    case (op)
      0: model_tick();
      1: mq = (mq + 1) % 4;
      2: mmode = (mmode + 1) % 4;
      default: model_set();
    endcase
    if (do_cmp) compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all("R1");
  endtask

  task automatic write_alarm(input int h, input int m, input int p, input int b);
    @(negedge clk);
    a_ht = 4'(h / 10); a_ho = 4'(h % 10); a_mt = 4'(m / 10); a_mo = 4'(m % 10);
    a_pm_in = p[0]; a_beep_in = b[0]; alarm_wr = 1;
    @(negedge clk);
    alarm_wr = 0;
    marmed = 1; mah = h; mam = m; mapm = p; mabeep = b;
    @(negedge clk);
    compare_all("R10");
  endtask

  // Move the clock to a given time via the adjust modes, ending in run.
  task automatic set_time(input int h, input int m, input int s, input int p, input string tag);
    apply(2, 1, "R4");
    while (mh != h || mpm != p) apply(3, 0, "R7");
    compare_all(tag);
    apply(2, 1, "R4");
    while (mm != m) apply(3, 0, "R6");
    compare_all(tag);
    apply(2, 1, "R4");
    while (ms != s) apply(3, 0, "R6");
    compare_all(tag);
    apply(2, 1, "R4");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    void'($urandom(32'd4242));
    do_reset();

    // R2: plain run seconds and minute carry
    for (int i = 0; i < 61; i++) apply(0, 1, "R2");

    // R3: 11:59:59 am -> 12:00:00 pm, then 12:59:59 -> 01:00:00
    set_time(11, 59, 59, 0, "R3");
    apply(0, 1, "R3");
    set_time(12, 59, 59, 1, "R3");
    apply(0, 1, "R3");

    // R6: set pulse in run mode is ignored
    apply(3, 1, "R6");

    // R5: ticks and blink during each adjust mode
    for (int k = 0; k < 3; k++) begin
      apply(2, 1, "R4");
      apply(1, 1, "R9");
      apply(1, 1, "R9");
      apply(0, 1, "R5");
      apply(1, 1, "R9");
      apply(1, 1, "R9");
      apply(1, 1, "R9");
    end
    apply(2, 1, "R4");

    // R8: wrap seconds to 00 in edit, then first run tick
    set_time(1, 59, 0, 0, "R8");
    apply(2, 1, "R4"); apply(2, 1, "R4"); apply(2, 1, "R4");
    for (int i = 0; i < 60; i++) apply(3, 0, "R8");
    apply(2, 1, "R4");
    apply(0, 1, "R8");

    // R7: hour adjust 11 -> 12 flips pm, minutes unaffected
    set_time(11, 30, 0, 1, "R7");
    apply(2, 1, "R4");
    apply(3, 1, "R7");
    apply(2, 1, "R4"); apply(2, 1, "R4"); apply(2, 1, "R4");

    // Random mix against the model (alarm disarmed)
    for (int i = 0; i < 500; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 55)      apply(0, 1, "R2");
      else if (r < 65) apply(1, 1, "R9");
      else if (r < 75) apply(2, 1, "R4");
      else             apply(3, 1, "R6");
    end

    // R10/R11: steady alarm at 12:01 am
    do_reset();
    write_alarm(12, 1, 0, 0);
    for (int i = 0; i < 59; i++) apply(0, 0, "R10");
    compare_all("R10");
    apply(0, 1, "R10");
    chk("R10", "buzzer at match", int'(buzzer), 1);
    for (int i = 0; i < 4; i++) begin
      apply(0, 1, "R11");
      chk("R11", "buzzer inside window", int'(buzzer), 1);
    end
    apply(0, 1, "R11");
    chk("R11", "buzzer after window", int'(buzzer), 0);

    // R10: pm mismatch must not fire
    do_reset();
    write_alarm(12, 1, 1, 0);
    for (int i = 0; i < 60; i++) apply(0, 0, "R10");
    compare_all("R10");
    chk("R10", "buzzer on pm mismatch", int'(buzzer), 0);

    // R12: beep style follows quarter phase
    do_reset();
    write_alarm(12, 1, 0, 1);
    for (int i = 0; i < 60; i++) apply(0, 0, "R12");
    compare_all("R12");
    chk("R12", "beep on at phase 0", int'(buzzer), 1);
    apply(1, 1, "R12");
    chk("R12", "beep off at phase 1", int'(buzzer), 0);
    apply(1, 1, "R12");
    chk("R12", "beep on at phase 2", int'(buzzer), 1);
    apply(1, 1, "R12");
    apply(0, 1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule